// File: doc/BRIEF.md
# Multicycle Control Sequencer with Exception Vectoring

This block is the hard-wired control unit of a small multicycle load/store processor. Each instruction runs through a short chain of states, starting at fetch and decode. From decode the unit branches on the opcode into one of several paths: memory access, register-to-register arithmetic, conditional branch or jump. In every state the unit drives the datapath select and enable lines. The ALU, the register file and memory sit outside the block. The block holds the program counter and its next-value selector, so branch and jump redirection happen inside it.

Two faults leave the normal flow. The first is an opcode the unit does not recognise. The second is a signed overflow during register-to-register execution. Each fault has its own state, which writes a one-bit fault code into a 32-bit cause register. Both fault states then pass through a common vectoring state. There the shared ALU computes PC minus 4, and that value is latched into the saved-PC register while the PC is loaded with a fixed handler address. Overflow diverts the machine before the register write-back state, so a faulting result never reaches the register file.

Top module: `mc_ctrl_trap`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes 0 (fetch), `pc` becomes the `RESET_PC` parameter (default 0), and `epc` and `cause` become 0. This holds even when reset hits the middle of an exception sequence.
- R2: State 0 goes to state 1. In state 1 the opcode selects the path. Opcode 0x23 goes through 2, 3, 4 and back to 0. Opcode 0x2B goes through 2, 5 and back to 0. Opcode 0x00 goes through 6, 7 and back to 0. Opcode 0x04 goes through 8 and back to 0. Opcode 0x02 goes through 9 and back to 0.
- R3: Any other opcode in state 1 leads to state 10. State 10 asserts `cause_write` with `int_cause`=0, so `cause` becomes 0x00000000. The fault code is always in bit 0 of `cause`, and bits 31..1 stay zero.
- R4: If `alu_ovf` is high in state 6, the next state is 11 instead of 7. State 11 asserts `cause_write` with `int_cause`=1, so `cause` becomes 0x00000001. On this path `reg_write` is never asserted.
- R5: States 10 and 11 both go to state 12, and state 12 goes to state 0. State 12 drives `alu_src_a`=0, `alu_src_b`=01, `alu_op`=01 (subtract), `epc_write`=1, `pc_write`=1 and `pc_source`=11.
- R6: When `epc_write` is high at a clock edge, `epc` loads `alu_result`. After a fault, `epc` therefore equals the address of the faulting instruction. Instructions that do not fault leave `epc` unchanged.
- R7: The PC loads its next value when `pc_write` is high, or when `pc_write_cond` and `alu_zero` are both high. `pc_source` picks the value: 00 takes `alu_result`, 01 takes `alu_out`, 10 takes the upper four PC bits followed by `jump_index` and two zero bits, and 11 takes the `HANDLER_ADDR` parameter (default 0x80000180).
- R8: The controls follow the state. State 0 asserts `mem_read`, `ir_write`, `pc_write` and `alu_src_b`=01, with `pc_source`=00. State 6 drives `alu_src_a`=1, `alu_src_b`=00 and `alu_op`=10. State 7 asserts `reg_write` and `reg_dst` with `mem_to_reg`=0. At most one of `reg_write`, `mem_write`, `epc_write` and `cause_write` is high at any time.
- R9: All control outputs are registered, and they change together with `state` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| alu_zero | input | 1 | ALU result is zero |
| alu_result | input | 32 | ALU output in the current cycle |
| alu_out | input | 32 | ALU result register (value from the previous cycle) |
| jump_index | input | 26 | Jump target field of the instruction |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| ir_write | output | 1 | Instruction register load |
| iord | output | 1 | Memory address select: 0 = PC, 1 = ALU register |
| reg_dst | output | 1 | Destination register select |
| mem_to_reg | output | 1 | Write-back data select |
| reg_write | output | 1 | Register file write enable |
| alu_src_a | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_src_b | output | 2 | ALU operand B: register B, 4, immediate, immediate shifted left by 2 |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 by function field |
| pc_write | output | 1 | Unconditional PC load |
| pc_write_cond | output | 1 | PC load when ALU result is zero |
| pc_source | output | 2 | PC next-value select |
| epc_write | output | 1 | Saved-PC register load |
| cause_write | output | 1 | Cause register load |
| int_cause | output | 1 | Fault code to be written |
| state | output | 4 | Current state number |
| pc | output | 32 | Program counter |
| epc | output | 32 | Saved PC of the last faulting instruction |
| cause | output | 32 | Fault code of the last fault |

## Verification
The bench acts as the ALU and the ALU result register, and then runs a table of instructions through the machine. The table covers a load, a store, a plain add, a branch taken and not taken, and a jump. It also has two adds that overflow, one positive and one negative, and two undefined opcodes. The recorded state path shows whether each opcode picks the right route. The overflowing adds show that the divert to state 11 happens and that it suppresses write-back. Interleaving the fault kinds makes the cause register flip between 0 and 1, which tells the two codes apart. A correct EPC after a fault that follows a jump to a new region shows that the subtract-4 adjustment works.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic [3:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_MADDR   = 4'd2,
    ST_MRD     = 4'd3,
    ST_LDWB    = 4'd4,
    ST_MWR     = 4'd5,
    ST_REXE    = 4'd6,
    ST_RWB     = 4'd7,
    ST_BEQ     = 4'd8,
    ST_JMP     = 4'd9,
    ST_ILLEGAL = 4'd10,
    ST_OVF     = 4'd11,
    ST_VECTOR  = 4'd12
  } state_e;

  localparam logic [1:0] PCS_ALU     = 2'b00;
  localparam logic [1:0] PCS_ALUOUT  = 2'b01;
  localparam logic [1:0] PCS_JUMP    = 2'b10;
  localparam logic [1:0] PCS_HANDLER = 2'b11;

  typedef struct packed {
    logic       mem_read;
    logic       mem_write;
    logic       ir_write;
    logic       iord;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       reg_write;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
    logic       pc_write;
    logic       pc_write_cond;
    logic [1:0] pc_source;
    logic       epc_write;
    logic       cause_write;
    logic       int_cause;
  } ctrl_t;

endpackage

// File: rtl/mct_next_state.sv
module mct_next_state
  import mct_pkg::*;
#(
  parameter int         OPW    = 6,
  parameter logic [5:0] OP_LW  = 6'h23,
  parameter logic [5:0] OP_SW  = 6'h2B,
  parameter logic [5:0] OP_RT  = 6'h00,
  parameter logic [5:0] OP_BEQ = 6'h04,
  parameter logic [5:0] OP_JMP = 6'h02
) (
  input  logic           clk,
  input  logic           rst,
  input  state_e         cur,
  input  logic [OPW-1:0] opcode,
  input  logic           alu_ovf,
  output state_e         nxt
);

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if      (opcode == OP_LW || opcode == OP_SW) nxt = ST_MADDR;
        else if (opcode == OP_RT)                    nxt = ST_REXE;
        else if (opcode == OP_BEQ)                   nxt = ST_BEQ;
        else if (opcode == OP_JMP)                   nxt = ST_JMP;
        else                                         nxt = ST_ILLEGAL;
      end
      ST_MADDR:   nxt = (opcode == OP_LW) ? ST_MRD : ST_MWR;
      ST_MRD:     nxt = ST_LDWB;
      ST_REXE:    nxt = alu_ovf ? ST_OVF : ST_RWB;
      ST_ILLEGAL: nxt = ST_VECTOR;
      ST_OVF:     nxt = ST_VECTOR;
      default:    nxt = ST_FETCH;
    endcase
  end

  // R3: an unknown opcode in decode goes to the illegal-opcode state
  assert_illegal_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_DECODE && opcode != OP_LW && opcode != OP_SW && opcode != OP_RT &&
     opcode != OP_BEQ && opcode != OP_JMP) |-> nxt == ST_ILLEGAL);

  // R4: overflow in execute goes to the overflow state
  assert_ovf_divert_R4: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_REXE && alu_ovf) |-> nxt == ST_OVF);

endmodule

// File: rtl/mct_decode.sv
module mct_decode
  import mct_pkg::*;
(
  input  state_e st,
  output ctrl_t  c
);

  always_comb begin
    c = '0;
    unique case (st)
      ST_FETCH: begin
        c.mem_read  = 1'b1;
        c.ir_write  = 1'b1;
        c.alu_src_b = 2'b01;
        c.pc_write  = 1'b1;
        c.pc_source = PCS_ALU;
      end
      ST_DECODE: c.alu_src_b = 2'b11;
      ST_MADDR: begin
        c.alu_src_a = 1'b1;
        c.alu_src_b = 2'b10;
      end
      ST_MRD: begin
        c.mem_read = 1'b1;
        c.iord     = 1'b1;
      end
      ST_LDWB: begin
        c.reg_write  = 1'b1;
        c.mem_to_reg = 1'b1;
      end
      ST_MWR: begin
        c.mem_write = 1'b1;
        c.iord      = 1'b1;
      end
      ST_REXE: begin
        c.alu_src_a = 1'b1;
        c.alu_op    = 2'b10;
      end
      ST_RWB: begin
        c.reg_dst   = 1'b1;
        c.reg_write = 1'b1;
      end
      ST_BEQ: begin
        c.alu_src_a     = 1'b1;
        c.alu_op        = 2'b01;
        c.pc_write_cond = 1'b1;
        c.pc_source     = PCS_ALUOUT;
      end
      ST_JMP: begin
        c.pc_write  = 1'b1;
        c.pc_source = PCS_JUMP;
      end
      ST_ILLEGAL: c.cause_write = 1'b1;
      ST_OVF: begin
        c.cause_write = 1'b1;
        c.int_cause   = 1'b1;
      end
      ST_VECTOR: begin
        c.alu_src_b = 2'b01;
        c.alu_op    = 2'b01;
        c.epc_write = 1'b1;
        c.pc_write  = 1'b1;
        c.pc_source = PCS_HANDLER;
      end
      default: c = '0;
    endcase
  end

endmodule

// File: rtl/mct_pc_unit.sv
module mct_pc_unit
  import mct_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter logic [XLEN-1:0] RESET_PC     = '0,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_write,
  input  logic            pc_write_cond,
  input  logic [1:0]      pc_source,
  input  logic            epc_write,
  input  logic            cause_write,
  input  logic            int_cause,
  input  logic            alu_zero,
  input  logic [XLEN-1:0] alu_result,
  input  logic [XLEN-1:0] alu_out,
  input  logic [XLEN-7:0] jump_index,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause
);

  localparam int JW = XLEN - 6;

  logic [XLEN-1:0] pc_next;
  logic            pc_load;

  always_comb begin
    unique case (pc_source)
      PCS_ALU:    pc_next = alu_result;
      PCS_ALUOUT: pc_next = alu_out;
      PCS_JUMP:   pc_next = {pc[XLEN-1:XLEN-4], jump_index[JW-1:0], 2'b00};
      default:    pc_next = HANDLER_ADDR;
    endcase
  end

  assign pc_load = pc_write | (pc_write_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= RESET_PC;
      epc   <= '0;
      cause <= '0;
    end else begin
      if (pc_load)     pc    <= pc_next;
      if (epc_write)   epc   <= alu_result;
      if (cause_write) cause <= {{(XLEN-1){1'b0}}, int_cause};
    end
  end

  // R6: the saved PC takes the ALU result of the vectoring cycle
  assert_epc_capture_R6: assert property (@(posedge clk) disable iff (rst)
    epc_write |=> epc == $past(alu_result));

  // R6: outside vectoring the saved PC holds its value
  assert_epc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !epc_write |=> $stable(epc));

  // R3: the upper cause bits stay clear
  assert_cause_upper_R3: assert property (@(posedge clk) disable iff (rst)
    cause_write |=> cause[XLEN-1:1] == '0 && cause[0] == $past(int_cause));

  // R7: selecting the handler lands on the handler address
  assert_handler_vector_R7: assert property (@(posedge clk) disable iff (rst)
    (pc_write && pc_source == PCS_HANDLER) |=> pc == HANDLER_ADDR);

  // R7: a branch that is not taken leaves the PC alone
  assert_branch_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!pc_write && !(pc_write_cond && alu_zero)) |=> $stable(pc));

endmodule

// File: rtl/mc_ctrl_trap.sv
module mc_ctrl_trap
  import mct_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter int              OPW          = 6,
  parameter logic [XLEN-1:0] RESET_PC     = '0,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  opcode,
  input  logic            alu_ovf,
  input  logic            alu_zero,
  input  logic [XLEN-1:0] alu_result,
  input  logic [XLEN-1:0] alu_out,
  input  logic [XLEN-7:0] jump_index,
  output logic            mem_read,
  output logic            mem_write,
  output logic            ir_write,
  output logic            iord,
  output logic            reg_dst,
  output logic            mem_to_reg,
  output logic            reg_write,
  output logic            alu_src_a,
  output logic [1:0]      alu_src_b,
  output logic [1:0]      alu_op,
  output logic            pc_write,
  output logic            pc_write_cond,
  output logic [1:0]      pc_source,
  output logic            epc_write,
  output logic            cause_write,
  output logic            int_cause,
  output logic [3:0]      state,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause
);

  state_e state_q, ns_raw, ns_eff;
  ctrl_t  ctrl_d, ctrl_q;

  mct_next_state #(.OPW(OPW)) u_ns (
    .clk    (clk),
    .rst    (rst),
    .cur    (state_q),
    .opcode (opcode),
    .alu_ovf(alu_ovf),
    .nxt    (ns_raw)
  );

  assign ns_eff = rst ? ST_FETCH : ns_raw;

  // Controls decoded from the next state are registered alongside it
  mct_decode u_dec (
    .st(ns_eff),
    .c (ctrl_d)
  );

  always_ff @(posedge clk) begin
    state_q <= ns_eff;
    ctrl_q  <= ctrl_d;
  end

  mct_pc_unit #(
    .XLEN        (XLEN),
    .RESET_PC    (RESET_PC),
    .HANDLER_ADDR(HANDLER_ADDR)
  ) u_pc (
    .clk          (clk),
    .rst          (rst),
    .pc_write     (ctrl_q.pc_write),
    .pc_write_cond(ctrl_q.pc_write_cond),
    .pc_source    (ctrl_q.pc_source),
    .epc_write    (ctrl_q.epc_write),
    .cause_write  (ctrl_q.cause_write),
    .int_cause    (ctrl_q.int_cause),
    .alu_zero     (alu_zero),
    .alu_result   (alu_result),
    .alu_out      (alu_out),
    .jump_index   (jump_index),
    .pc           (pc),
    .epc          (epc),
    .cause        (cause)
  );

  assign state         = state_q;
  assign mem_read      = ctrl_q.mem_read;
  assign mem_write     = ctrl_q.mem_write;
  assign ir_write      = ctrl_q.ir_write;
  assign iord          = ctrl_q.iord;
  assign reg_dst       = ctrl_q.reg_dst;
  assign mem_to_reg    = ctrl_q.mem_to_reg;
  assign reg_write     = ctrl_q.reg_write;
  assign alu_src_a     = ctrl_q.alu_src_a;
  assign alu_src_b     = ctrl_q.alu_src_b;
  assign alu_op        = ctrl_q.alu_op;
  assign pc_write      = ctrl_q.pc_write;
  assign pc_write_cond = ctrl_q.pc_write_cond;
  assign pc_source     = ctrl_q.pc_source;
  assign epc_write     = ctrl_q.epc_write;
  assign cause_write   = ctrl_q.cause_write;
  assign int_cause     = ctrl_q.int_cause;

  // R1: reset returns the machine to fetch
  assert_reset_fetch_R1: assert property (@(posedge clk)
    rst |=> state_q == ST_FETCH);

  // R5: both fault states lead into vectoring
  assert_fault_to_vector_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ILLEGAL || state_q == ST_OVF) |=> state_q == ST_VECTOR);

  // R5: vectoring goes back to fetch
  assert_vector_to_fetch_R5: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_VECTOR |=> state_q == ST_FETCH);

  // R4: overflow in execute suppresses write-back on the next cycle
  assert_no_wb_on_ovf_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REXE && alu_ovf) |=> !reg_write && state_q == ST_OVF);

  // R8: the major write enables never overlap
  assert_one_writer_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl_q.reg_write, ctrl_q.mem_write, ctrl_q.epc_write, ctrl_q.cause_write}));

endmodule

// File: tb/tb_mc_ctrl_trap.sv
module tb_mc_ctrl_trap;

  localparam logic [31:0] HANDLER = 32'h8000_0180;
  localparam logic [25:0] JIDX    = 26'h0123456;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = 6'h00;
  logic        alu_ovf, alu_zero;
  logic [31:0] alu_result, alu_out_q;
  logic [31:0] reg_a = '0, reg_b = '0;
  logic [15:0] imm = '0;
  logic        mem_read, mem_write, ir_write, iord, reg_dst, mem_to_reg, reg_write;
  logic        alu_src_a, pc_write, pc_write_cond, epc_write, cause_write, int_cause;
  logic [1:0]  alu_src_b, alu_op, pc_source;
  logic [3:0]  state;
  logic [31:0] pc, epc, cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mc_ctrl_trap #(.HANDLER_ADDR(HANDLER)) dut (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf), .alu_zero(alu_zero),
    .alu_result(alu_result), .alu_out(alu_out_q), .jump_index(JIDX),
    .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write), .iord(iord),
    .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_write(reg_write),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
    .pc_write(pc_write), .pc_write_cond(pc_write_cond), .pc_source(pc_source),
    .epc_write(epc_write), .cause_write(cause_write), .int_cause(int_cause),
    .state(state), .pc(pc), .epc(epc), .cause(cause)
  );

  // ALU and ALU result register modelled by the bench
  logic [31:0] opa, opb, sext;
  always_comb begin
    sext = {{16{imm[15]}}, imm};
    opa  = alu_src_a ? reg_a : pc;
    case (alu_src_b)
      2'b00:   opb = reg_b;
      2'b01:   opb = 32'd4;
      2'b10:   opb = sext;
      default: opb = sext << 2;
    endcase
    alu_result = (alu_op == 2'b01) ? opa - opb : opa + opb;
    alu_ovf    = (alu_op == 2'b10) && (opa[31] == opb[31]) && (alu_result[31] != opa[31]);
    alu_zero   = (alu_result == 32'd0);
  end
  always_ff @(posedge clk) alu_out_q <= alu_result;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] im;
    logic [19:0] path;  // state numbers, first in the low nibble
    logic [2:0]  len;
    logic [1:0]  kind;  // 0 next, 1 branch taken, 2 jump, 3 handler
    logic [1:0]  code;  // 2 = cause unchanged
    logic        regw;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{6'h23, 32'd100,        32'd0,          16'd8, 20'h43210, 3'd5, 2'd0, 2'd2, 1'b1},
    '{6'h2B, 32'd100,        32'd0,          16'd8, 20'h05210, 3'd4, 2'd0, 2'd2, 1'b0},
    '{6'h00, 32'd5,          32'd6,          16'd0, 20'h07610, 3'd4, 2'd0, 2'd2, 1'b1},
    '{6'h00, 32'h7FFF_FFFF,  32'd1,          16'd0, 20'hCB610, 3'd5, 2'd3, 2'd1, 1'b0},
    '{6'h04, 32'd3,          32'd3,          16'd4, 20'h00810, 3'd3, 2'd1, 2'd2, 1'b0},
    '{6'h04, 32'd3,          32'd4,          16'd4, 20'h00810, 3'd3, 2'd0, 2'd2, 1'b0},
    '{6'h02, 32'd0,          32'd0,          16'd0, 20'h00910, 3'd3, 2'd2, 2'd2, 1'b0},
    '{6'h3F, 32'd0,          32'd0,          16'd0, 20'h0CA10, 3'd4, 2'd3, 2'd0, 1'b0},
    '{6'h00, 32'h8000_0000,  32'hFFFF_FFFF,  16'd0, 20'hCB610, 3'd5, 2'd3, 2'd1, 1'b0},
    '{6'h01, 32'd0,          32'd0,          16'd0, 20'h0CA10, 3'd4, 2'd3, 2'd0, 1'b0}
  };

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] exp_epc, exp_cause, exp_pc, p;
    logic        saw_wr;
    exp_epc   = '0;
    exp_cause = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values (sampled before the first edge out of reset)
    chk("R1 state", {28'd0, state}, 32'd0);
    chk("R1 pc", pc, 32'd0);
    chk("R1 epc", epc, 32'd0);
    chk("R1 cause", cause, 32'd0);
    // R9/R8: fetch controls are already present on entry to state 0
    chk("R8 fetch ctl", {27'd0, mem_read, ir_write, pc_write, alu_src_b},
        {27'd0, 1'b1, 1'b1, 1'b1, 2'b01});

    foreach (VECS[i]) begin
      opcode = VECS[i].op;
      reg_a  = VECS[i].a;
      reg_b  = VECS[i].b;
      imm    = VECS[i].im;
      p      = pc;
      saw_wr = 1'b0;
      for (int k = 0; k < int'(VECS[i].len); k++) begin
        if (k > 0) @(negedge clk);
        chk("R2 path", {28'd0, state}, {28'd0, VECS[i].path[4*k +: 4]});
        saw_wr |= reg_write;
        if (state == 4'd0)
          chk("R8 fetch pcsrc", {30'd0, pc_source}, 32'd0);
        if (state == 4'd6)
          chk("R8 exec ctl", {27'd0, alu_src_a, alu_src_b, alu_op}, {27'd0, 1'b1, 2'b00, 2'b10});
        if (state == 4'd7)
          chk("R8 wb ctl", {29'd0, reg_write, reg_dst, mem_to_reg}, {29'd0, 3'b110});
        if (state == 4'd10)
          chk("R3 illegal ctl", {30'd0, cause_write, int_cause}, {30'd0, 2'b10});
        if (state == 4'd11)
          chk("R4 ovf ctl", {30'd0, cause_write, int_cause}, {30'd0, 2'b11});
        if (state == 4'd12)
          chk("R5 vector ctl",
              {22'd0, alu_src_a, alu_src_b, alu_op, epc_write, pc_write, pc_source},
              {22'd0, 1'b0, 2'b01, 2'b01, 1'b1, 1'b1, 2'b11});
      end
      @(negedge clk);
      chk("R5 back to fetch", {28'd0, state}, 32'd0);
      case (VECS[i].kind)
        2'd0: exp_pc = p + 32'd4;
        2'd1: exp_pc = p + 32'd4 + ({{16{VECS[i].im[15]}}, VECS[i].im} << 2);
        2'd2: exp_pc = {p[31:28] + 4'd0, JIDX, 2'b00};
        default: exp_pc = HANDLER;
      endcase
      if (VECS[i].kind == 2'd2) begin
        logic [31:0] pn;
        pn = p + 32'd4;
        exp_pc = {pn[31:28], JIDX, 2'b00};
      end
      if (VECS[i].kind == 2'd3) exp_epc = p;
      if (VECS[i].code != 2'd2) exp_cause = {31'd0, VECS[i].code[0]};
      chk("R7 pc", pc, exp_pc);
      chk("R6 epc", epc, exp_epc);
      chk(VECS[i].code == 2'd0 ? "R3 cause" : "R4 cause", cause, exp_cause);
      chk("R4 regwrite seen", {31'd0, saw_wr}, {31'd0, VECS[i].regw});
    end

    // R1: reset during the overflow state clears the exception state
    opcode = 6'h00;
    reg_a  = 32'h7FFF_FFFF;
    reg_b  = 32'd1;
    repeat (3) @(negedge clk);
    chk("R4 in ovf state", {28'd0, state}, 32'd11);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset state", {28'd0, state}, 32'd0);
    chk("R1 mid reset pc", pc, 32'd0);
    chk("R1 mid reset epc", epc, 32'd0);
    chk("R1 mid reset cause", cause, 32'd0);
    finish_run();
  end

endmodule